// File: doc/BRIEF.md
# Max-min fair rate allocator

This block splits one fixed capacity among a small set of customers so that the smallest share handed out is as large as it can be. Each customer presents an unsigned fixed-point demand. A start pulse latches every demand and the capacity. The block then runs a water-filling loop. On each step it takes the smallest demand that is still open and asks whether that demand fits under an equal split of what is left. If it fits, that customer gets its full demand and the remainder shrinks. If it does not fit, every open customer receives the same truncated share of the remainder and the loop ends.

Demands, capacity and allocations share one fixed-point format. The position of the binary point does not affect the arithmetic, because the only division is by an integer head count. The bench uses 8 fraction bits. Truncation residue stays unallocated. When the loop ends, the block raises a one-cycle done pulse and holds the allocation vector until the next accepted start.

Top module: `maxmin_alloc`

## Requirements
- R1: After reset, busyO and doneO are 0 and every allocation field of allocO is 0.
- R2: No customer's allocation exceeds its latched demand.
- R3: The sum of all allocations never exceeds the latched capacity.
- R4: When the sum of the demands is at most the capacity, every customer receives exactly its demand.
- R5: A customer with zero demand is treated as satisfied at once and receives 0.
- R6: Open customers are visited in ascending order of demand, with ties going to the lowest index. A visited demand d is granted in full when d times the open count is at most the remainder. The first demand that fails this test ends the loop, and every still-open customer then gets floor(remainder / open count). With 8 fraction bits, demands 2, 2.6, 4, 5 (512, 666, 1024, 1280) and capacity 10 (2560) give 512, 666, 691, 691.
- R7: A start that arrives while busyO is 1 is ignored. The result is the one for the demands and capacity latched at the accepted start.
- R8: doneO is a one-cycle pulse raised with busyO low. allocO then holds its value until the next accepted start.
- R9: At most NUM_CUST full grants happen per run. doneO rises no more than NUM_CUST + CAP_W + 4 cycles after the edge that accepts start.
- R10: Customer i's demand sits at demandsI[i*DEM_W +: DEM_W], and its allocation sits at allocO[i*DEM_W +: DEM_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startI | input | 1 | Starts a computation when idle |
| capacityI | input | CAP_W | Capacity to share |
| demandsI | input | NUM_CUST*DEM_W | Packed demands, customer 0 in the low field |
| busyO | output | 1 | Computation in progress |
| doneO | output | 1 | One-cycle completion pulse |
| allocO | output | NUM_CUST*DEM_W | Packed allocations |

## Verification
The assertions assume a few things about the inputs. The parameters are chosen so that capacityI fits CAP_W bits and NUM_CUST is at least 2. They also assume that the serial divider is started only while at least one customer is open, so its divisor is never zero. The stimulus stays inside these limits. It draws every demand and the capacity within their port widths. It mixes small demands with tight capacities so that the runs take both the full-grant path and the division path. Start is raised mid-run only in the one directed case that tests its rejection.

// File: rtl/maxmin_pkg.sv
package maxmin_pkg;
  typedef struct packed {
    logic load;   // latch inputs, open all nonzero customers
    logic take;   // grant smallest open demand in full
    logic divGo;  // launch residual / open-count division
    logic fill;   // hand quotient to every open customer
  } mmStrobe_t;
endpackage

// File: rtl/maxmin_minsel.sv
module maxmin_minsel #(
  parameter int NUM_CUST = 4,
  parameter int DEM_W    = 16,
  localparam int IDX_W   = $clog2(NUM_CUST)
) (
  input  logic [DEM_W-1:0] demIn [NUM_CUST],
  input  logic [NUM_CUST-1:0] openIn,
  output logic [IDX_W-1:0] minIdx,
  output logic [DEM_W-1:0] minVal,
  output logic             anyOpen
);
  // Lowest open demand; ties resolve to lowest index (strict less-than).
  always_comb begin
    minIdx  = '0;
    minVal  = '1;
    anyOpen = 1'b0;
    for (int i = 0; i < NUM_CUST; i++) begin
      if (openIn[i] && (!anyOpen || demIn[i] < minVal)) begin
        minIdx  = IDX_W'(i);
        minVal  = demIn[i];
        anyOpen = 1'b1;
      end
    end
  end
endmodule

// File: rtl/maxmin_divider.sv
module maxmin_divider #(
  parameter int NUM_W = 18,
  parameter int DEN_W = 3,
  localparam int STEP_W = $clog2(NUM_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             goIn,
  input  logic [NUM_W-1:0] numIn,
  input  logic [DEN_W-1:0] denIn,
  output logic [NUM_W-1:0] quotOut,
  output logic             doneOut
);
  logic [DEN_W-1:0]  remR;
  logic [NUM_W-1:0]  quoR;
  logic [NUM_W-1:0]  numR;
  logic [DEN_W-1:0]  denR;
  logic [STEP_W-1:0] stepR;
  logic              runR;
  logic              doneR;
  logic [DEN_W:0]    shifted;
  logic              geq;

  assign shifted = {remR, quoR[NUM_W-1]};
  assign geq     = shifted >= {1'b0, denR};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR <= '0; quoR <= '0; numR <= '0; denR <= '0;
      stepR <= '0; runR <= 1'b0; doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (goIn) begin
        remR  <= '0;
        quoR  <= numIn;
        numR  <= numIn;
        denR  <= denIn;
        stepR <= STEP_W'(NUM_W);
        runR  <= 1'b1;
      end else if (runR) begin
        if (geq) begin
          remR <= DEN_W'(shifted - {1'b0, denR});
          quoR <= {quoR[NUM_W-2:0], 1'b1};
        end else begin
          remR <= shifted[DEN_W-1:0];
          quoR <= {quoR[NUM_W-2:0], 1'b0};
        end
        stepR <= stepR - 1'b1;
        if (stepR == STEP_W'(1)) begin
          runR  <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign quotOut = quoR;
  assign doneOut = doneR;

  // R6: quotient is the truncated (floor) result
  a_r6_div_floor: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> ((NUM_W+DEN_W)'(quoR) * (NUM_W+DEN_W)'(denR) <= (NUM_W+DEN_W)'(numR)) &&
              ((NUM_W+DEN_W)'(numR) - (NUM_W+DEN_W)'(quoR) * (NUM_W+DEN_W)'(denR)
                 < (NUM_W+DEN_W)'(denR)));
  a_r6_div_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    goIn |-> denIn != '0);
endmodule

// File: rtl/maxmin_ctrl.sv
module maxmin_ctrl
  import maxmin_pkg::*;
#(
  parameter int NUM_CUST = 4,
  localparam int ITER_W  = $clog2(NUM_CUST + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  input  logic      anyOpen,
  input  logic      fits,
  input  logic      divDone,
  output mmStrobe_t strb,
  output logic      busyOut,
  output logic      doneOut
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_DIV} mmState_t;
  mmState_t stateR;
  logic [ITER_W-1:0] iterR;
  logic doneR;

  always_comb begin
    strb = '0;
    unique case (stateR)
      S_IDLE: strb.load  = startIn;
      S_SCAN: begin
        strb.take  = anyOpen && fits;
        strb.divGo = anyOpen && !fits;
      end
      S_DIV:  strb.fill  = divDone;
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR <= S_IDLE;
      iterR  <= '0;
      doneR  <= 1'b0;
    end else begin
      doneR <= 1'b0;
      unique case (stateR)
        S_IDLE: if (startIn) begin
          stateR <= S_SCAN;
          iterR  <= '0;
        end
        S_SCAN: begin
          if (!anyOpen) begin
            stateR <= S_IDLE;
            doneR  <= 1'b1;
          end else if (fits) begin
            iterR <= iterR + 1'b1;
          end else begin
            stateR <= S_DIV;
          end
        end
        S_DIV: if (divDone) stateR <= S_SCAN;
        default: stateR <= S_IDLE;
      endcase
    end
  end

  assign busyOut = stateR != S_IDLE;
  assign doneOut = doneR;

  // R9: full grants per run bounded by customer count
  a_r9_iter_bound: assert property (@(posedge clk) disable iff (!rstN)
    iterR <= ITER_W'(NUM_CUST));
  // R8: done is a single-cycle pulse while idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> !doneR);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> !busyOut);
  // R7: a start seen while busy never loads
  a_r7_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && startIn) |-> !strb.load);
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/maxmin_dpath.sv
module maxmin_dpath
  import maxmin_pkg::*;
#(
  parameter int NUM_CUST = 4,
  parameter int DEM_W    = 16,
  parameter int CAP_W    = 18,
  localparam int CNT_W   = $clog2(NUM_CUST + 1),
  localparam int IDX_W   = $clog2(NUM_CUST),
  localparam int CMP_W   = (DEM_W + CNT_W > CAP_W) ? DEM_W + CNT_W : CAP_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  mmStrobe_t                 strb,
  input  logic [CAP_W-1:0]          capIn,
  input  logic [NUM_CUST*DEM_W-1:0] demFlat,
  output logic                      anyOpen,
  output logic                      fits,
  output logic                      divDone,
  output logic [NUM_CUST*DEM_W-1:0] allocFlat
);
  logic [DEM_W-1:0]    demR   [NUM_CUST];
  logic [DEM_W-1:0]    allocR [NUM_CUST];
  logic [NUM_CUST-1:0] openR;
  logic [CAP_W-1:0]    capR;
  logic [CAP_W-1:0]    remR;
  logic [CNT_W-1:0]    openCnt;
  logic [IDX_W-1:0]    minIdx;
  logic [DEM_W-1:0]    minVal;
  logic [CAP_W-1:0]    share;
  logic [DEM_W-1:0]    shareClamp;

  maxmin_minsel #(.NUM_CUST(NUM_CUST), .DEM_W(DEM_W)) uMinSel (
    .demIn(demR), .openIn(openR),
    .minIdx(minIdx), .minVal(minVal), .anyOpen(anyOpen)
  );

  maxmin_divider #(.NUM_W(CAP_W), .DEN_W(CNT_W)) uDiv (
    .clk(clk), .rstN(rstN), .goIn(strb.divGo),
    .numIn(remR), .denIn(openCnt),
    .quotOut(share), .doneOut(divDone)
  );

  always_comb begin
    openCnt = '0;
    for (int i = 0; i < NUM_CUST; i++) openCnt = openCnt + CNT_W'(openR[i]);
  end

  // smallest demand fits under an equal split of the remainder
  assign fits = CMP_W'(minVal) * CMP_W'(openCnt) <= CMP_W'(remR);
  assign shareClamp = (share > CAP_W'({DEM_W{1'b1}})) ? '1 : share[DEM_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openR <= '0;
      capR  <= '0;
      remR  <= '0;
      for (int i = 0; i < NUM_CUST; i++) begin
        demR[i]   <= '0;
        allocR[i] <= '0;
      end
    end else if (strb.load) begin
      capR <= capIn;
      remR <= capIn;
      for (int i = 0; i < NUM_CUST; i++) begin
        demR[i]   <= demFlat[i*DEM_W +: DEM_W];
        allocR[i] <= '0;
        openR[i]  <= demFlat[i*DEM_W +: DEM_W] != '0;
      end
    end else if (strb.take) begin
      allocR[minIdx] <= minVal;
      openR[minIdx]  <= 1'b0;
      remR           <= remR - CAP_W'(minVal);
    end else if (strb.fill) begin
      for (int i = 0; i < NUM_CUST; i++) begin
        if (openR[i]) allocR[i] <= shareClamp;
      end
      openR <= '0;
    end
  end

  for (genvar g = 0; g < NUM_CUST; g++) begin : gOut
    assign allocFlat[g*DEM_W +: DEM_W] = allocR[g];
    // R2: allocation never above demand
    a_r2_alloc_le_demand: assert property (@(posedge clk) disable iff (!rstN)
      allocR[g] <= demR[g]);
    // R5: zero demand stays at zero allocation
    a_r5_zero_demand: assert property (@(posedge clk) disable iff (!rstN)
      (demR[g] == '0) |-> (allocR[g] == '0) && !openR[g]);
  end

  // R3: remainder only shrinks below the latched capacity
  a_r3_rem_le_cap: assert property (@(posedge clk) disable iff (!rstN)
    remR <= capR);
  // R6: the equal share lies below the smallest open demand
  a_r6_fill_below: assert property (@(posedge clk) disable iff (!rstN)
    strb.fill |-> (share < CAP_W'(minVal)));
endmodule

// File: rtl/maxmin_alloc.sv
module maxmin_alloc
  import maxmin_pkg::*;
#(
  parameter int NUM_CUST = 4,
  parameter int DEM_W    = 16,
  parameter int CAP_W    = 18
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startI,
  input  logic [CAP_W-1:0]          capacityI,
  input  logic [NUM_CUST*DEM_W-1:0] demandsI,
  output logic                      busyO,
  output logic                      doneO,
  output logic [NUM_CUST*DEM_W-1:0] allocO
);
  mmStrobe_t strb;
  logic anyOpen, fits, divDone;

  maxmin_ctrl #(.NUM_CUST(NUM_CUST)) uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startI),
    .anyOpen(anyOpen), .fits(fits), .divDone(divDone),
    .strb(strb), .busyOut(busyO), .doneOut(doneO)
  );

  maxmin_dpath #(.NUM_CUST(NUM_CUST), .DEM_W(DEM_W), .CAP_W(CAP_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .capIn(capacityI), .demFlat(demandsI),
    .anyOpen(anyOpen), .fits(fits), .divDone(divDone),
    .allocFlat(allocO)
  );

  // R8: allocation held while idle and not starting
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busyO && !startI) |=> $stable(allocO));
endmodule

// File: tb/maxmin_alloc_test.sv
module maxmin_alloc_test;
  localparam int NC = 4;
  localparam int DW = 16;
  localparam int CW = 18;
  localparam int MAXLAT = NC + CW + 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startI = 1'b0;
  logic [CW-1:0] capacityI = '0;
  logic [NC*DW-1:0] demandsI = '0;
  logic busyO, doneO;
  logic [NC*DW-1:0] allocO;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  maxmin_alloc #(.NUM_CUST(NC), .DEM_W(DW), .CAP_W(CW)) uut (
    .clk(clk), .rstN(rstN), .startI(startI), .capacityI(capacityI),
    .demandsI(demandsI), .busyO(busyO), .doneO(doneO), .allocO(allocO)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // water-filling reference taken from the requirements
  function automatic void model(input int d[NC], input int cap, output int a[NC]);
    bit open[NC];
    longint rem = cap;
    for (int i = 0; i < NC; i++) begin a[i] = 0; open[i] = d[i] != 0; end
    for (int step = 0; step <= NC; step++) begin
      int idx = -1; int cnt = 0;
      for (int i = 0; i < NC; i++) if (open[i]) begin
        cnt++;
        if (idx < 0 || d[i] < d[idx]) idx = i;
      end
      if (idx < 0) break;
      if (longint'(d[idx]) * cnt <= rem) begin
        a[idx] = d[idx]; open[idx] = 1'b0; rem -= d[idx];
      end else begin
        for (int i = 0; i < NC; i++) if (open[i]) a[i] = int'(rem / cnt);
        break;
      end
    end
  endfunction

  function automatic int getAlloc(input int i);
    return int'(allocO[i*DW +: DW]);
  endfunction

  task automatic drive(input int d[NC], input int cap);
    capacityI = CW'(cap);
    for (int i = 0; i < NC; i++) demandsI[i*DW +: DW] = DW'(d[i]);
  endtask

  task automatic waitDone(output int lat);
    lat = 1;
    while (!doneO && lat < 200) begin @(negedge clk); lat++; end
  endtask

  task automatic runAndCheck(input int d[NC], input int cap, input string tag);
    int exp[NC]; int lat; longint sum = 0; longint dsum = 0;
    model(d, cap, exp);
    @(negedge clk); drive(d, cap); startI = 1'b1;
    @(negedge clk); startI = 1'b0;
    waitDone(lat);
    check(doneO == 1'b1, "R9 done reached", doneO, 1);
    check(lat <= MAXLAT, "R9 latency", lat, MAXLAT);
    check(busyO == 1'b0, "R8 busy low at done", busyO, 0);
    for (int i = 0; i < NC; i++) begin
      check(getAlloc(i) == exp[i], {"R6 ", tag}, getAlloc(i), exp[i]);
      check(getAlloc(i) <= d[i], "R2 alloc le demand", getAlloc(i), d[i]);
      if (d[i] == 0) check(getAlloc(i) == 0, "R5 zero demand", getAlloc(i), 0);
      sum += getAlloc(i); dsum += d[i];
    end
    check(sum <= cap, "R3 sum le capacity", sum, cap);
    if (dsum <= cap)
      for (int i = 0; i < NC; i++)
        check(getAlloc(i) == d[i], "R4 all satisfied", getAlloc(i), d[i]);
    @(negedge clk);
    check(doneO == 1'b0, "R8 done pulse", doneO, 0);
    for (int i = 0; i < NC; i++)
      check(getAlloc(i) == exp[i], "R8 alloc held", getAlloc(i), exp[i]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int d[NC]; int a[NC]; int lat;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busyO == 0 && doneO == 0, "R1 reset flags", {busyO, doneO}, 0);
    check(allocO == '0, "R1 reset alloc", allocO, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R6 worked example, R10 field order: 512,666,1024,1280 / 2560
    d = '{512, 666, 1024, 1280};
    runAndCheck(d, 2560, "example");
    check(getAlloc(0) == 512 && getAlloc(1) == 666, "R10 low fields", getAlloc(1), 666);
    check(getAlloc(2) == 691 && getAlloc(3) == 691, "R6 example share", getAlloc(3), 691);

    // R4 ample capacity
    d = '{100, 3000, 7, 65535};
    runAndCheck(d, 200000, "ample");
    // R5 zeros mixed in, R6 ties
    d = '{0, 500, 0, 500};
    runAndCheck(d, 600, "zero and tie");
    d = '{0, 0, 0, 0};
    runAndCheck(d, 1000, "all zero");
    // zero capacity
    d = '{5, 6, 7, 8};
    runAndCheck(d, 0, "zero capacity");
    // truncation residue: 10 / 3 each
    d = '{9, 9, 9, 0};
    runAndCheck(d, 10, "truncate");
    // exactly equal to capacity
    d = '{1, 2, 3, 4};
    runAndCheck(d, 10, "exact fit");

    // R7 start while busy is ignored
    begin
      int dB[NC]; int exp[NC];
      d  = '{400, 800, 1200, 1600};
      dB = '{1, 1, 1, 1};
      model(d, 1000, exp);
      @(negedge clk); drive(d, 1000); startI = 1'b1;
      @(negedge clk); startI = 1'b0;
      @(negedge clk);
      drive(dB, 5); startI = 1'b1;
      @(negedge clk); startI = 1'b0;
      waitDone(lat);
      check(doneO == 1'b1, "R7 done after restart attempt", doneO, 1);
      for (int i = 0; i < NC; i++)
        check(getAlloc(i) == exp[i], "R7 start ignored", getAlloc(i), exp[i]);
      @(negedge clk);
      check(busyO == 1'b0, "R7 no second run", busyO, 0);
    end

    // constrained random
    for (int t = 0; t < 60; t++) begin
      int cap;
      for (int i = 0; i < NC; i++) begin
        case ($urandom % 4)
          0: d[i] = 0;
          1: d[i] = int'($urandom % 256);
          2: d[i] = int'($urandom % 4096);
          default: d[i] = int'($urandom % 65536);
        endcase
      end
      cap = int'($urandom % (1 << CW));
      if (t % 3 == 0) cap = int'($urandom % 8192);
      runAndCheck(d, cap, "random");
    end

    model(d, 0, a);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule